// File: doc/BRIEF.md
# MSI Target Address Generator

This block turns an interrupt delivery decision into a single memory write. It keeps two address configurations, one for the machine privilege level and one for the supervisor level. Each configuration is a pair of 32-bit words. From a hart index, a guest index, an interrupt identity and a level select, the block builds a 56-bit byte address. It then issues one 32-bit write of the identity through a valid/ready write port and waits for the response. Software can also force an MSI by writing a dedicated register.

The hart index is split into two parts. A group part sits high in the page number and a low part sits lower down. Where each part lands, and how wide it is, comes from fields in the high configuration word. The guest index fills the lowest page-number bits, and the page number is then shifted up by the 4 KiB page offset. A lock bit in the machine high word freezes all four address words until reset.

Top module: `msi_addr_gen`

## Requirements
- R1: `cfg_sel` picks a register: 0 machine low word, 1 machine high word, 2 supervisor low word, 3 supervisor high word, 4 forced-MSI word. `cfg_rdata` returns the selected register combinationally. A high word stores only the bits of mask 0x9F77FFFF: lock 31, HHXS 28:24, LHXS 22:20, HHXW 18:16, LHXW 15:12, base 11:0.
- R2: Once bit 31 of the machine high word is set, writes to selects 0 to 3 have no effect until reset.
- R3: While `child_present` is low, selects 2 and 3 read as zero and writes to them are dropped.
- R4: The page number is the OR of four terms: {base, low word}; ((hart >> LHXW) masked to HHXW bits) shifted left by HHXS+12; (hart masked to LHXW bits) shifted left by LHXS; and the guest index masked to LHXS bits. `wr_addr` is the low 44 bits of that page number followed by 12 zero bits.
- R5: `wr_data` carries the 11-bit identity in bits 10:0, with zeros above.
- R6: A request with `req_sup` low uses the machine pair and guest index 0. A request with `req_sup` high uses the supervisor pair and `req_guest`.
- R7: Only one write is outstanding at a time. `req_ready` is high only when the port is idle, no forced MSI is waiting, and no forced-MSI write is happening this cycle. An accepted request raises `wr_valid` on the next cycle. `wr_valid`, `wr_addr` and `wr_data` hold until `wr_ready`. The port becomes idle on the cycle after `wr_resp_valid`.
- R8: `err_flag` is set by a response with `wr_resp_err` high and stays set until reset.
- R9: A write to select 4 stores the value with bits 17:12 cleared. It then sends exactly one MSI on the machine pair, with the hart index from bits 31:18, the identity from bits 10:0 and guest index 0. A waiting forced MSI is launched before any pending request.
- R10: After reset all registers read zero, `wr_valid` and `err_flag` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| child_present | input | 1 | A supervisor child domain exists (static strap) |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Selected register value |
| req_valid | input | 1 | Delivery request valid |
| req_ready | output | 1 | Delivery request accepted |
| req_sup | input | 1 | 1 = supervisor level, 0 = machine level |
| req_hart | input | 14 | Target hart index |
| req_guest | input | 6 | Guest index (supervisor only) |
| req_eiid | input | 11 | Interrupt identity |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request taken |
| wr_addr | output | 56 | Write byte address |
| wr_data | output | 32 | Write data |
| wr_resp_valid | input | 1 | Write response valid |
| wr_resp_err | input | 1 | Write response reports failure |
| err_flag | output | 1 | Sticky write-failure flag |

## Verification
A wrong field extraction or shift shows up in `wr_addr` on the first cycle of `wr_valid` after the request is accepted, so each address pattern exposes it one cycle after the handshake. Corrupted register contents or a broken lock show up in `cfg_rdata` in the same cycle that the register is selected. A wrong port state shows up as `req_ready` or `wr_valid` disagreeing with the expected idle/busy sequence at the very next clock. The forced-MSI ordering error only appears when a request and a forced MSI compete while the port is stalled, so that case is driven on purpose.

// File: rtl/msi_gen_pkg.sv
package msi_gen_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned HART_W     = 14;
    localparam int unsigned GUEST_W    = 6;
    localparam int unsigned EIID_W     = 11;
    localparam int unsigned SEL_W      = 3;
    localparam int unsigned PAGE_SHIFT = 12;
    localparam int unsigned ADDR_W     = 56;
    localparam int unsigned PPN_W      = ADDR_W - PAGE_SHIFT;
    localparam int unsigned WIDE_W     = 64;

    // high word field layout (decoded by the composer)
    localparam int unsigned LOCK_BIT   = 31;
    localparam int unsigned HHXS_LSB   = 24;
    localparam int unsigned HHXS_W     = 5;
    localparam int unsigned LHXS_LSB   = 20;
    localparam int unsigned LHXS_W     = 3;
    localparam int unsigned HHXW_LSB   = 16;
    localparam int unsigned HHXW_W     = 3;
    localparam int unsigned LHXW_LSB   = 12;
    localparam int unsigned LHXW_W     = 4;
    localparam int unsigned BASE_W     = 12;
    localparam logic [WORD_W-1:0] HI_KEEP = 32'h9F77_FFFF;

    // forced-MSI word layout
    localparam int unsigned FRC_HART_LSB = 18;
    localparam int unsigned FRC_GAP_LSB  = 12;
    localparam int unsigned FRC_GAP_W    = 6;
    localparam logic [WORD_W-1:0] FRC_CLR =
        WORD_W'(((1 << FRC_GAP_W) - 1) << FRC_GAP_LSB);

    localparam logic [SEL_W-1:0] SEL_M_LO  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_M_HI  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_S_LO  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_S_HI  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_FORCE = 3'd4;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } addr_pair_t;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_SEND = 2'd1,
        PS_WAIT = 2'd2
    } port_st_e;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
    import msi_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              child_present,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output addr_pair_t        m_pair,
    output addr_pair_t        s_pair,
    output logic [WORD_W-1:0] force_word,
    output logic              force_fire
);
    typedef struct packed {
        addr_pair_t        m;
        addr_pair_t        s;
        logic [WORD_W-1:0] frc;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic locked;

    always_comb begin
        cfg_d      = cfg_q;
        locked     = cfg_q.m.hi[LOCK_BIT];
        force_fire = 1'b0;
        rdata      = '0;
        case (sel)
            SEL_M_LO: begin
                rdata = cfg_q.m.lo;
                if (we && !locked) cfg_d.m.lo = wdata;
            end
            SEL_M_HI: begin
                rdata = cfg_q.m.hi;
                if (we && !locked) cfg_d.m.hi = wdata & HI_KEEP;
            end
            SEL_S_LO: begin
                rdata = child_present ? cfg_q.s.lo : '0;
                if (we && !locked && child_present) cfg_d.s.lo = wdata;
            end
            SEL_S_HI: begin
                rdata = child_present ? cfg_q.s.hi : '0;
                if (we && !locked && child_present) cfg_d.s.hi = wdata & HI_KEEP;
            end
            SEL_FORCE: begin
                rdata = cfg_q.frc;
                if (we) begin
                    cfg_d.frc  = wdata & ~FRC_CLR;
                    force_fire = 1'b1;
                end
            end
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign m_pair     = cfg_q.m;
    assign s_pair     = cfg_q.s;
    assign force_word = cfg_q.frc;
endmodule

// File: rtl/msi_addr_compose.sv
module msi_addr_compose
    import msi_gen_pkg::*;
(
    input  addr_pair_t         pair,
    input  logic [HART_W-1:0]  hart,
    input  logic [GUEST_W-1:0] guest,
    output logic [ADDR_W-1:0]  addr
);
    logic [HHXS_W-1:0]  hhxs;
    logic [LHXS_W-1:0]  lhxs;
    logic [HHXW_W-1:0]  hhxw;
    logic [LHXW_W-1:0]  lhxw;
    logic [BASE_W-1:0]  base;
    logic [HART_W-1:0]  grp;
    logic [HART_W-1:0]  low_hart;
    logic [GUEST_W-1:0] guest_m;
    logic [6:0]         grp_shift;
    logic [WIDE_W-1:0]  ppn;

    always_comb begin
        hhxs      = pair.hi[HHXS_LSB +: HHXS_W];
        lhxs      = pair.hi[LHXS_LSB +: LHXS_W];
        hhxw      = pair.hi[HHXW_LSB +: HHXW_W];
        lhxw      = pair.hi[LHXW_LSB +: LHXW_W];
        base      = pair.hi[BASE_W-1:0];
        grp       = (hart >> lhxw) & ((HART_W'(1) << hhxw) - HART_W'(1));
        low_hart  = hart & ((HART_W'(1) << lhxw) - HART_W'(1));
        guest_m   = guest & ((GUEST_W'(1) << lhxs) - GUEST_W'(1));
        grp_shift = 7'(hhxs) + 7'(PAGE_SHIFT);
        ppn       = {{(WIDE_W - BASE_W - WORD_W){1'b0}}, base, pair.lo}
                  | (WIDE_W'(grp) << grp_shift)
                  | (WIDE_W'(low_hart) << lhxs)
                  | WIDE_W'(guest_m);
        addr      = {ppn[PPN_W-1:0], {PAGE_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/msi_port_ctrl.sv
module msi_port_ctrl
    import msi_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] launch_addr,
    input  logic [WORD_W-1:0] launch_data,
    output logic              idle,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              resp_valid,
    input  logic              resp_err,
    output logic              err_flag
);
    typedef struct packed {
        port_st_e          st;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic              err;
    } port_t;

    port_t port_d, port_q;

    always_comb begin
        port_d = port_q;
        case (port_q.st)
            PS_IDLE: begin
                if (launch) begin
                    port_d.st   = PS_SEND;
                    port_d.addr = launch_addr;
                    port_d.data = launch_data;
                end
            end
            PS_SEND: begin
                if (wr_ready) port_d.st = PS_WAIT;
            end
            PS_WAIT: begin
                if (resp_valid) begin
                    port_d.st = PS_IDLE;
                    if (resp_err) port_d.err = 1'b1;
                end
            end
            default: port_d.st = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) port_q <= '{st: PS_IDLE, addr: '0, data: '0, err: 1'b0};
        else        port_q <= port_d;
    end

    assign idle     = (port_q.st == PS_IDLE);
    assign wr_valid = (port_q.st == PS_SEND);
    assign wr_addr  = port_q.addr;
    assign wr_data  = port_q.data;
    assign err_flag = port_q.err;
endmodule

// File: rtl/msi_addr_gen.sv
module msi_addr_gen
    import msi_gen_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               child_present,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [WORD_W-1:0]  cfg_wdata,
    output logic [WORD_W-1:0]  cfg_rdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_sup,
    input  logic [HART_W-1:0]  req_hart,
    input  logic [GUEST_W-1:0] req_guest,
    input  logic [EIID_W-1:0]  req_eiid,
    output logic               wr_valid,
    input  logic               wr_ready,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [WORD_W-1:0]  wr_data,
    input  logic               wr_resp_valid,
    input  logic               wr_resp_err,
    output logic               err_flag
);
    typedef struct packed {
        logic fpend;
    } top_t;

    top_t top_d, top_q;

    addr_pair_t         m_pair, s_pair, sel_pair;
    logic [WORD_W-1:0]  force_word;
    logic               force_fire;
    logic               idle;
    logic               launch;
    logic               use_force;
    logic               use_sup;
    logic [HART_W-1:0]  sel_hart;
    logic [GUEST_W-1:0] sel_guest;
    logic [EIID_W-1:0]  sel_eiid;
    logic [ADDR_W-1:0]  comp_addr;

    msi_cfg_regs u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .child_present (child_present),
        .we            (cfg_we),
        .sel           (cfg_sel),
        .wdata         (cfg_wdata),
        .rdata         (cfg_rdata),
        .m_pair        (m_pair),
        .s_pair        (s_pair),
        .force_word    (force_word),
        .force_fire    (force_fire)
    );

    always_comb begin
        top_d     = top_q;
        req_ready = idle && !top_q.fpend && !force_fire;
        use_force = top_q.fpend;
        launch    = idle && (use_force || (req_valid && req_ready));
        use_sup   = !use_force && req_sup;
        sel_pair  = use_sup ? s_pair : m_pair;
        sel_hart  = use_force ? force_word[FRC_HART_LSB +: HART_W] : req_hart;
        sel_guest = use_sup ? req_guest : '0;
        sel_eiid  = use_force ? force_word[EIID_W-1:0] : req_eiid;
        if (force_fire)               top_d.fpend = 1'b1;
        else if (idle && top_q.fpend) top_d.fpend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    msi_addr_compose u_comp (
        .pair  (sel_pair),
        .hart  (sel_hart),
        .guest (sel_guest),
        .addr  (comp_addr)
    );

    msi_port_ctrl u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .launch_addr (comp_addr),
        .launch_data (WORD_W'(sel_eiid)),
        .idle        (idle),
        .wr_valid    (wr_valid),
        .wr_ready    (wr_ready),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .resp_valid  (wr_resp_valid),
        .resp_err    (wr_resp_err),
        .err_flag    (err_flag)
    );
endmodule

// File: rtl/msi_addr_gen_chk.sv
module msi_addr_gen_chk
    import msi_gen_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              child_present,
    input logic              cfg_we,
    input logic [SEL_W-1:0]  cfg_sel,
    input logic [WORD_W-1:0] cfg_rdata,
    input logic              req_ready,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic              err_flag,
    input addr_pair_t        m_pair,
    input addr_pair_t        s_pair
);
    // R2: a set lock freezes all four address words
    a_r2_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        m_pair.hi[LOCK_BIT] |=> ($stable(m_pair) && $stable(s_pair)));

    // R3: supervisor words hidden without a child domain
    a_r3_sup_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (!child_present && (cfg_sel == SEL_S_LO || cfg_sel == SEL_S_HI)) |-> (cfg_rdata == '0));

    // R5: identity fits in the low bits
    a_r5_data_width: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_data[WORD_W-1:EIID_W] == '0));

    // R7: held while stalled
    a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R7: no acceptance while a write is outstanding
    a_r7_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !req_ready);

    // R8: error flag is sticky
    a_r8_sticky_err: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R9: forced-MSI write blocks requests in that cycle
    a_r9_force_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_FORCE) |-> !req_ready);
endmodule

bind msi_addr_gen msi_addr_gen_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .child_present (child_present),
    .cfg_we        (cfg_we),
    .cfg_sel       (cfg_sel),
    .cfg_rdata     (cfg_rdata),
    .req_ready     (req_ready),
    .wr_valid      (wr_valid),
    .wr_ready      (wr_ready),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .err_flag      (err_flag),
    .m_pair        (m_pair),
    .s_pair        (s_pair)
);

// File: tb/sim_msi_addr_gen.sv
module sim_msi_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        child_present = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_sup = 1'b0;
    logic [13:0] req_hart = '0;
    logic [5:0]  req_guest = '0;
    logic [10:0] req_eiid = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [55:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_resp_valid = 1'b0;
    logic        wr_resp_err = 1'b0;
    logic        err_flag;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    bit err_inject = 0;
    bit pend_resp = 0;
    string phase = "R10";

    msi_addr_gen u0 (.*);

    always #5 clk = ~clk;

    // ---------------- reference model ----------------
    int unsigned mlo, mhi, slo, shi, frc;
    bit fpend, merr;
    int mst;
    longint unsigned maddr;
    int unsigned mdata;

    function automatic longint unsigned mk_addr(int unsigned lo, int unsigned hi,
                                                int unsigned hart, int unsigned guest);
        int unsigned hhxs = (hi >> 24) & 31;
        int unsigned lhxs = (hi >> 20) & 7;
        int unsigned hhxw = (hi >> 16) & 7;
        int unsigned lhxw = (hi >> 12) & 15;
        longint unsigned grp  = (longint'(hart) >> lhxw) & ((64'd1 << hhxw) - 1);
        longint unsigned lowh = longint'(hart) & ((64'd1 << lhxw) - 1);
        longint unsigned g    = longint'(guest) & ((64'd1 << lhxs) - 1);
        longint unsigned ppn;
        ppn = (longint'(hi & 32'hFFF) << 32) | longint'(lo) | (grp << (hhxs + 12))
            | (lowh << lhxs) | g;
        return (ppn << 12) & ((64'd1 << 56) - 1);
    endfunction

    function automatic int unsigned model_rd(int s);
        case (s)
            0: return mlo;
            1: return mhi;
            2: return child_present ? slo : 0;
            3: return child_present ? shi : 0;
            4: return frc;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mlo = 0; mhi = 0; slo = 0; shi = 0; frc = 0;
            fpend = 0; merr = 0; mst = 0; maddr = 0; mdata = 0;
        end else begin
            bit fire, rdy, lck;
            int nst;
            fire = cfg_we && cfg_sel == 3'd4;
            rdy  = (mst == 0) && !fpend && !fire;
            nst  = mst;
            if (mst == 0) begin
                if (fpend) begin
                    maddr = mk_addr(mlo, mhi, frc >> 18, 0);
                    mdata = frc & 32'h7FF;
                    nst = 1;
                end else if (req_valid && rdy) begin
                    if (req_sup) maddr = mk_addr(slo, shi, req_hart, req_guest);
                    else         maddr = mk_addr(mlo, mhi, req_hart, 0);
                    mdata = req_eiid;
                    nst = 1;
                end
            end else if (mst == 1) begin
                if (wr_ready) nst = 2;
            end else if (wr_resp_valid) begin
                nst = 0;
                if (wr_resp_err) merr = 1;
            end
            if (fire) fpend = 1;
            else if (mst == 0 && fpend) fpend = 0;
            mst = nst;
            lck = mhi[31];
            if (cfg_we) begin
                case (cfg_sel)
                    3'd0: if (!lck) mlo = cfg_wdata;
                    3'd1: if (!lck) mhi = cfg_wdata & 32'h9F77FFFF;
                    3'd2: if (!lck && child_present) slo = cfg_wdata;
                    3'd3: if (!lck && child_present) shi = cfg_wdata & 32'h9F77FFFF;
                    3'd4: frc = cfg_wdata & ~32'h0003F000;
                    default: ;
                endcase
            end
        end
    end

    // ---------------- write sink ----------------
    always @(negedge clk) if (wr_valid && wr_ready) pend_resp = 1;
    always @(posedge clk) begin
        #1;
        wr_resp_valid = pend_resp;
        wr_resp_err   = pend_resp && err_inject;
        pend_resp     = 0;
    end

    // ---------------- comparison ----------------
    task automatic chk(string tag, string what, longint unsigned act, longint unsigned exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s (%s, phase %s): actual %0h expected %0h", tag, what, phase, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1", "cfg_rdata", cfg_rdata, model_rd(cfg_sel));
            chk("R7", "req_ready", req_ready,
                (mst == 0) && !fpend && !(cfg_we && cfg_sel == 3'd4));
            chk("R7", "wr_valid", wr_valid, mst == 1);
            chk("R8", "err_flag", err_flag, merr);
            if (mst == 1) begin
                chk("R4", "wr_addr", wr_addr, maddr);
                chk("R5", "wr_data", wr_data, mdata);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cfg_wr(input logic [2:0] s, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_we = 1; cfg_sel = s; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 0;
    endtask

    task automatic cfg_look(input logic [2:0] s);
        @(posedge clk); #1;
        cfg_sel = s;
        @(posedge clk); #1;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(mst == 0 && !fpend)) @(negedge clk);
    endtask

    task automatic wait_accept();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic post(input bit sup, input int hart, input int guest, input int eiid);
        @(posedge clk); #1;
        req_valid = 1; req_sup = sup;
        req_hart = 14'(hart); req_guest = 6'(guest); req_eiid = 11'(eiid);
        wait_accept();
    endtask

    task automatic send(input bit sup, input int hart, input int guest, input int eiid);
        post(sup, hart, guest, eiid);
        wait_idle();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: run did not finish (phase %s)", phase);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // ---------------- test sequence ----------------
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R10: reset state at the ports
        @(negedge clk);
        chk("R10", "reset wr_valid", wr_valid, 0);
        chk("R10", "reset err_flag", err_flag, 0);
        chk("R10", "reset req_ready", req_ready, 1);
        chk("R10", "reset cfg_rdata", cfg_rdata, 0);

        // R1: masking of high words and readback of every select
        phase = "R1";
        cfg_wr(3'd1, 32'h7FFF_FFFF);
        cfg_look(3'd1);
        cfg_wr(3'd0, 32'h1234_5000);
        cfg_look(3'd0);
        cfg_wr(3'd3, 32'h6ABC_DEF1);
        cfg_look(3'd3);
        cfg_wr(3'd2, 32'h0BAD_0000);
        cfg_look(3'd2);

        // R4 / R6: machine level, several field settings
        phase = "R4";
        cfg_wr(3'd1, (3 << 24) | (2 << 20) | (2 << 16) | (3 << 12) | 32'hABC);
        cfg_wr(3'd0, 32'h0001_0000);
        send(0, 14'h2D, 7, 11'h123);
        send(0, 14'h3FFF, 0, 11'h7FF);
        cfg_wr(3'd1, (31 << 24) | (7 << 20) | (7 << 16) | (15 << 12) | 32'hFFF);
        send(0, 14'h1555, 63, 11'h001);
        cfg_wr(3'd1, 32'h0);
        send(0, 14'h0AAA, 5, 11'h400);

        // R6: supervisor pair with guest index
        phase = "R6";
        cfg_wr(3'd3, (5 << 24) | (6 << 20) | (3 << 16) | (4 << 12) | 32'h012);
        cfg_wr(3'd2, 32'h8000_0000);
        send(1, 14'h0F3, 6'h2A, 11'h055);
        send(1, 14'h3FFF, 6'h3F, 11'h3FF);

        // R7: stalled port, back-to-back requests
        phase = "R7";
        wr_ready = 0;
        post(0, 14'h11, 0, 11'h0AA);
        @(posedge clk); #1 req_valid = 1; req_sup = 1; req_hart = 14'h22; req_eiid = 11'h0BB;
        repeat (4) @(posedge clk);
        #1 wr_ready = 1;
        wait_accept();
        wait_idle();

        // R8: error response sets sticky flag
        phase = "R8";
        err_inject = 1;
        send(0, 14'h5, 0, 11'h5);
        err_inject = 0;
        send(0, 14'h6, 0, 11'h6);

        // R9: forced MSI, readback and priority over a waiting request
        phase = "R9";
        cfg_wr(3'd1, (1 << 24) | (1 << 20) | (2 << 16) | (2 << 12) | 32'h00F);
        cfg_wr(3'd4, 32'hFFFF_FFFF);
        cfg_look(3'd4);
        wait_idle();
        wr_ready = 0;
        post(0, 14'h33, 0, 11'h033);
        @(posedge clk); #1 req_valid = 1; req_sup = 0; req_hart = 14'h44; req_eiid = 11'h044;
        cfg_wr(3'd4, 32'h0123_4567);
        repeat (3) @(posedge clk);
        #1 wr_ready = 1;
        wait_accept();
        wait_idle();

        // R3: supervisor words hidden and write-protected without a child
        phase = "R3";
        #1 child_present = 0;
        cfg_wr(3'd2, 32'hDEAD_BEEF);
        cfg_look(3'd2);
        cfg_look(3'd3);
        #1 child_present = 1;
        cfg_look(3'd2);

        // R2: lock freezes all four address words
        phase = "R2";
        cfg_wr(3'd1, 32'h8000_0000 | (2 << 24) | (1 << 20) | (1 << 16) | (1 << 12));
        cfg_wr(3'd1, 32'h0);
        cfg_look(3'd1);
        cfg_wr(3'd0, 32'hFFFF_0000);
        cfg_look(3'd0);
        cfg_wr(3'd2, 32'h0);
        cfg_look(3'd2);
        cfg_wr(3'd3, 32'h0);
        cfg_look(3'd3);
        send(0, 14'h7, 0, 11'h077);
        send(1, 14'h9, 3, 11'h099);

        repeat (3) @(posedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule